// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It watches a shared 16-bit free-running count and works in one of three ways. It can be released from its pin, which then follows a general-purpose I/O path. It can be an input capture channel, which records the count when a chosen edge arrives on the pin. It can be an unbuffered output compare/PWM channel, which changes its output level when the count equals its stored value.

A small write port holds the channel's control field, its 16-bit value register and its event flag. The control field has one mode bit and a two-bit edge/level field. When the edge/level field is nonzero, the mode bit picks compare (1) or capture (0). When the edge/level field is zero, the mode bit presets the level the channel will drive once it is connected. An overflow strobe from the counter returns a PWM output to a known level at the start of each period.

Top module: `tcc_channel`

## Requirements
- R1: After reset the mode bit is 0, the edge/level field is 00, the value register is 0, the flag is 0, the channel level is 1, and the pin follows the general-purpose path.
- R2: A control write (`wr_addr` = 0, `wr_data[2]` = mode, `wr_data[1:0]` = edge/level) takes effect only while both `tmr_stop` and `tmr_hold` are 1. Otherwise it leaves the control field unchanged.
- R3: While the edge/level field is 00, `pin_out`/`pin_oe` equal `gpio_out`/`gpio_oe`, and the channel level settles to the inverse of the mode bit (mode 1 gives level 0, mode 0 gives level 1).
- R4: In capture mode (field nonzero, mode 0) `pin_oe` is 0. In compare mode (field nonzero, mode 1) `pin_oe` is 1 and `pin_out` shows the channel level, starting from the level preset while the channel was released.
- R5: In capture mode the field picks the trigger: 01 rising, 10 falling, 11 either. The pin passes through two synchronizing flops. The third rising clock after a qualifying pin change copies `cnt` into the value register and sets the flag. An edge that does not qualify changes nothing.
- R6: In compare mode, at a clock edge where `cnt` equals the value register, the field's action is applied to the level (01 toggle, 10 drive 0, 11 drive 1) and the flag is set.
- R7: In compare mode an overflow strobe drives the level opposite to the action (10 gives 1, 11 gives 0, 01 no change). A match on the same edge takes priority over the overflow.
- R8: The flag is cleared by a write with `wr_addr` = 2 and `wr_data[0]` = 0, but only if a `rd_stat` pulse saw the flag at 1 after the last such write. A clearing write without that read leaves the flag set.
- R9: A capture or compare event on the same edge as a valid clearing write leaves the flag set.
- R10: A write with `wr_addr` = 1 loads `wr_data` into the value register at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_stop | input | 1 | Timer stopped |
| tmr_hold | input | 1 | Timer counter held in reset |
| cnt | input | 16 | Shared free-running count |
| cnt_ovf | input | 1 | Counter overflow strobe |
| pin_in | input | 1 | Pin level seen from the pad |
| gpio_out | input | 1 | General-purpose output data |
| gpio_oe | input | 1 | General-purpose output enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 value, 2 flag |
| wr_data | input | 16 | Write data |
| rd_stat | input | 1 | Software read of the flag |
| pin_out | output | 1 | Data to the pad |
| pin_oe | output | 1 | Output enable to the pad |
| ch_mode | output | 1 | Mode bit |
| ch_edge | output | 2 | Edge/level field |
| ch_value | output | 16 | Capture/compare value register |
| ch_flag | output | 1 | Channel event flag |
| ch_level | output | 1 | Channel output level |

## Verification
A compare match and a counter overflow strobe can land on the same clock edge, and so can a channel event and a valid software flag clear. The bench forces both pairs. It sets `cnt` equal to the value register and raises `cnt_ovf` in that cycle, then checks that the level follows the match action and not the overflow. It also issues an armed clearing write in the same cycle as a match, then checks that the flag stays set.

// File: rtl/tcc_pkg.sv
// Package: shared encodings for the timer capture/compare channel.
// Assumes a two-bit edge/level field whose zero value releases the pin.
package tcc_pkg;

    // Edge/level field values; meaning depends on capture versus compare.
    typedef enum logic [1:0] {
        EL_OFF  = 2'b00,
        EL_A    = 2'b01,   // capture: rising  / compare: toggle
        EL_B    = 2'b10,   // capture: falling / compare: drive 0
        EL_C    = 2'b11    // capture: both    / compare: drive 1
    } edge_lvl_t;

    // Register select on the write port.
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'b00,
        SEL_VALUE = 2'b01,
        SEL_FLAG  = 2'b10,
        SEL_NONE  = 2'b11
    } reg_sel_t;

    localparam int CTRL_W = 3;

endpackage

// File: rtl/tcc_regs.sv
// Module: control field and event flag of the channel.
// Control writes are honoured only while the timer is stopped and held.
// The flag clear needs a prior read that saw the flag set; a new event wins.
module tcc_regs
    import tcc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_stop,
    input  logic              tmr_hold,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stat,
    input  logic              evt,
    output logic              mode,
    output edge_lvl_t         edge_sel,
    output logic              flag
);

    logic ctrl_wr;
    logic flag_wr;
    logic armed;

    assign ctrl_wr = wr_en && (reg_sel_t'(wr_addr) == SEL_CTRL);
    assign flag_wr = wr_en && (reg_sel_t'(wr_addr) == SEL_FLAG);

    // Purpose: load the control field when the timer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= 1'b0;
            edge_sel <= EL_OFF;
        end else if (ctrl_wr && tmr_stop && tmr_hold) begin
            mode     <= wr_data[CTRL_W-1];
            edge_sel <= edge_lvl_t'(wr_data[1:0]);
        end
    end

    // Purpose: set the flag on events, clear it on an armed write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (evt) begin
                flag <= 1'b1;
            end else if (flag_wr && !wr_data[0] && armed) begin
                flag <= 1'b0;
            end
            if (flag_wr) begin
                armed <= 1'b0;
            end else if (rd_stat && flag) begin
                armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tcc_capture.sv
// Module: pin synchronizer and edge detector for input capture.
// Assumes pin_in is asynchronous; SYNC_STAGES flops precede detection.
module tcc_capture
    import tcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_in,
    input  logic      enable,
    input  edge_lvl_t edge_sel,
    output logic      cap_evt
);

    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] shreg;
    logic          rise;
    logic          fall;

    // Purpose: shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[LAST-1:0], pin_in};
        end
    end

    assign rise = shreg[LAST-1] && !shreg[LAST];
    assign fall = !shreg[LAST-1] && shreg[LAST];

    // Purpose: qualify detected edges with the selected trigger.
    always_comb begin
        cap_evt = 1'b0;
        if (enable) begin
            unique case (edge_sel)
                EL_A:    cap_evt = rise;
                EL_B:    cap_evt = fall;
                EL_C:    cap_evt = rise || fall;
                default: cap_evt = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tcc_compare.sv
// Module: value register and channel output level.
// Holds the capture/compare value; applies match and overflow actions.
// While released, the level tracks the inverse of the mode bit.
module tcc_compare
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_ovf,
    input  logic             mode,
    input  edge_lvl_t        edge_sel,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_evt,
    output logic [CNT_W-1:0] value,
    output logic             level,
    output logic             cmp_evt
);

    logic cmp_mode;

    assign cmp_mode = mode && (edge_sel != EL_OFF);
    assign cmp_evt  = cmp_mode && (cnt == value);

    // Purpose: capture the count, or take a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (cap_evt) begin
            value <= cnt;
        end else if (val_wr) begin
            value <= wr_data;
        end
    end

    // Purpose: update the channel level from preset, match or overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b1;
        end else if (edge_sel == EL_OFF) begin
            level <= !mode;
        end else if (cmp_evt) begin
            unique case (edge_sel)
                EL_A:    level <= !level;
                EL_B:    level <= 1'b0;
                EL_C:    level <= 1'b1;
                default: level <= level;
            endcase
        end else if (cmp_mode && cnt_ovf) begin
            unique case (edge_sel)
                EL_B:    level <= 1'b1;
                EL_C:    level <= 1'b0;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/tcc_pinmux.sv
// Module: pad multiplexer between the channel and general-purpose I/O.
// Purely combinational; the released state hands the pad to the I/O path.
module tcc_pinmux
    import tcc_pkg::*;
(
    input  logic      mode,
    input  edge_lvl_t edge_sel,
    input  logic      level,
    input  logic      gpio_out,
    input  logic      gpio_oe,
    output logic      pin_out,
    output logic      pin_oe
);

    // Purpose: pick the pad driver from the channel configuration.
    always_comb begin
        if (edge_sel == EL_OFF) begin
            pin_out = gpio_out;
            pin_oe  = gpio_oe;
        end else if (mode) begin
            pin_out = level;
            pin_oe  = 1'b1;
        end else begin
            pin_out = 1'b0;
            pin_oe  = 1'b0;
        end
    end

endmodule

// File: rtl/tcc_channel.sv
// Module: top of one timer capture/compare channel.
// Assumes the count, overflow strobe and stop/hold controls come from a
// shared timer; the pin input is asynchronous to clk.
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_stop,
    input  logic             tmr_hold,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_ovf,
    input  logic             pin_in,
    input  logic             gpio_out,
    input  logic             gpio_oe,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_stat,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             ch_mode,
    output logic [1:0]       ch_edge,
    output logic [CNT_W-1:0] ch_value,
    output logic             ch_flag,
    output logic             ch_level
);

    edge_lvl_t edge_sel;
    logic      cap_evt;
    logic      cmp_evt;
    logic      cap_en;
    logic      val_wr;

    assign cap_en  = !ch_mode && (edge_sel != EL_OFF);
    assign val_wr  = wr_en && (reg_sel_t'(wr_addr) == SEL_VALUE);
    assign ch_edge = edge_sel;

    tcc_regs #(.DATA_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_stop (tmr_stop),
        .tmr_hold (tmr_hold),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_stat  (rd_stat),
        .evt      (cap_evt || cmp_evt),
        .mode     (ch_mode),
        .edge_sel (edge_sel),
        .flag     (ch_flag)
    );

    tcc_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .enable   (cap_en),
        .edge_sel (edge_sel),
        .cap_evt  (cap_evt)
    );

    tcc_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .cnt_ovf  (cnt_ovf),
        .mode     (ch_mode),
        .edge_sel (edge_sel),
        .val_wr   (val_wr),
        .wr_data  (wr_data),
        .cap_evt  (cap_evt),
        .value    (ch_value),
        .level    (ch_level),
        .cmp_evt  (cmp_evt)
    );

    tcc_pinmux u_mux (
        .mode     (ch_mode),
        .edge_sel (edge_sel),
        .level    (ch_level),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: rtl/tcc_channel_chk.sv
// Module: property checker for tcc_channel, attached by bind below.
module tcc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_stop,
    input logic             tmr_hold,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_ovf,
    input logic             gpio_out,
    input logic             gpio_oe,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             ch_mode,
    input logic [1:0]       ch_edge,
    input logic [CNT_W-1:0] ch_value,
    input logic             ch_flag,
    input logic             ch_level
);

    AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'b00 && !(tmr_stop && tmr_hold))
        |=> $stable({ch_mode, ch_edge})); // R2

    AST_RELEASED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_edge == 2'b00) |-> (pin_out == gpio_out && pin_oe == gpio_oe)); // R3

    AST_CAPTURE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_edge != 2'b00 && !ch_mode) |-> !pin_oe); // R4

    AST_COMPARE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_edge != 2'b00 && ch_mode) |-> (pin_oe && pin_out == ch_level)); // R4

    AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mode && ch_edge == 2'b11 && cnt == ch_value) |=> (ch_level && ch_flag)); // R6

    AST_OVF_CLEAR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mode && ch_edge == 2'b10 && cnt_ovf && cnt != ch_value) |=> ch_level); // R7

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_flag && !(wr_en && wr_addr == 2'b10)) |=> ch_flag); // R8

endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_stop (tmr_stop),
    .tmr_hold (tmr_hold),
    .cnt      (cnt),
    .cnt_ovf  (cnt_ovf),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .ch_mode  (ch_mode),
    .ch_edge  (ch_edge),
    .ch_value (ch_value),
    .ch_flag  (ch_flag),
    .ch_level (ch_level)
);

// File: tb/tb_tcc_channel.sv
// Directed bench for tcc_channel: one task per scenario.
module tb_tcc_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_stop = 1'b1;
    logic        tmr_hold = 1'b1;
    logic [15:0] cnt = 16'd5;
    logic        cnt_ovf = 1'b0;
    logic        pin_in = 1'b0;
    logic        gpio_out = 1'b1;
    logic        gpio_oe = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'b00;
    logic [15:0] wr_data = 16'd0;
    logic        rd_stat = 1'b0;
    logic        pin_out, pin_oe, ch_mode, ch_flag, ch_level;
    logic [1:0]  ch_edge;
    logic [15:0] ch_value;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = !clk;

    tcc_channel dut (
        .clk(clk), .rst_n(rst_n), .tmr_stop(tmr_stop), .tmr_hold(tmr_hold),
        .cnt(cnt), .cnt_ovf(cnt_ovf), .pin_in(pin_in), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stat(rd_stat), .pin_out(pin_out), .pin_oe(pin_oe), .ch_mode(ch_mode),
        .ch_edge(ch_edge), .ch_value(ch_value), .ch_flag(ch_flag), .ch_level(ch_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        rd_stat = 1'b1; tick(1); rd_stat = 1'b0;
        wr(2'b10, 16'd0);
    endtask

    task automatic t_reset();
        check("R1 mode", ch_mode, 0);
        check("R1 edge", ch_edge, 0);
        check("R1 value", ch_value, 0);
        check("R1 flag", ch_flag, 0);
        check("R1 level", ch_level, 1);
        check("R1 pin_out", pin_out, 1);
        check("R1 pin_oe", pin_oe, 1);
    endtask

    task automatic t_lock();
        tmr_stop = 1'b0; tmr_hold = 1'b1;
        wr(2'b00, 16'h0007);
        check("R2 stop low", {ch_mode, ch_edge}, 0);
        tmr_stop = 1'b1; tmr_hold = 1'b0;
        wr(2'b00, 16'h0007);
        check("R2 hold low", {ch_mode, ch_edge}, 0);
        tmr_hold = 1'b1;
        wr(2'b00, 16'h0007);
        check("R2 accepted", {ch_mode, ch_edge}, 7);
        wr(2'b00, 16'h0000);
        check("R2 back off", {ch_mode, ch_edge}, 0);
    endtask

    task automatic t_release();
        wr(2'b00, 16'h0004);
        tick(1);
        check("R3 preset low", ch_level, 0);
        gpio_out = 1'b0; gpio_oe = 1'b0; #1;
        check("R3 pin_out gpio", pin_out, 0);
        check("R3 pin_oe gpio", pin_oe, 0);
        wr(2'b00, 16'h0000);
        tick(1);
        check("R3 preset high", ch_level, 1);
        wr(2'b00, 16'h0004);
        tick(1);
    endtask

    task automatic t_compare();
        cnt = 16'd7;
        wr(2'b01, 16'd100);
        check("R10 value write", ch_value, 100);
        wr(2'b00, 16'h0007);
        check("R4 cmp oe", pin_oe, 1);
        check("R4 initial low", pin_out, 0);
        cnt = 16'd99; tick(1);
        check("R6 no match", ch_level, 0);
        cnt = 16'd100; tick(1); cnt = 16'd101;
        check("R6 set level", ch_level, 1);
        check("R6 flag", ch_flag, 1);
        wr(2'b10, 16'd0);
        check("R8 unarmed clear", ch_flag, 1);
        clear_flag();
        check("R8 armed clear", ch_flag, 0);
        wr(2'b00, 16'h0005);
        cnt = 16'd100; tick(1); cnt = 16'd101;
        check("R6 toggle", ch_level, 0);
        tick(1);
        check("R6 toggle hold", ch_level, 0);
    endtask

    task automatic t_overflow();
        wr(2'b00, 16'h0006);
        cnt_ovf = 1'b1; tick(1); cnt_ovf = 1'b0;
        check("R7 ovf clear-mode", ch_level, 1);
        cnt = 16'd100; tick(1); cnt = 16'd101;
        check("R6 clear level", ch_level, 0);
        wr(2'b00, 16'h0007);
        cnt = 16'd100; tick(1); cnt = 16'd101;
        cnt_ovf = 1'b1; tick(1); cnt_ovf = 1'b0;
        check("R7 ovf set-mode", ch_level, 0);
        wr(2'b00, 16'h0006);
        cnt_ovf = 1'b1; tick(1);
        cnt = 16'd100; tick(1); cnt = 16'd101; cnt_ovf = 1'b0;
        check("R7 match beats ovf", ch_level, 0);
        wr(2'b00, 16'h0005);
        cnt_ovf = 1'b1; tick(1); cnt_ovf = 1'b0;
        check("R7 toggle ignores ovf", ch_level, 0);
    endtask

    task automatic t_flag_race();
        wr(2'b00, 16'h0006);
        check("R9 flag set before", ch_flag, 1);
        rd_stat = 1'b1; tick(1); rd_stat = 1'b0;
        wr_en = 1'b1; wr_addr = 2'b10; wr_data = 16'd0; cnt = 16'd100;
        tick(1);
        wr_en = 1'b0; cnt = 16'd101;
        check("R9 event wins", ch_flag, 1);
        clear_flag();
        check("R9 later clear", ch_flag, 0);
    endtask

    task automatic t_capture();
        wr(2'b00, 16'h0001);
        check("R4 cap oe", pin_oe, 0);
        tick(3);
        clear_flag();
        cnt = 16'd1234; pin_in = 1'b1;
        tick(2);
        check("R5 sync delay", ch_flag, 0);
        tick(1);
        check("R5 rise flag", ch_flag, 1);
        check("R5 rise value", ch_value, 1234);
        clear_flag();
        wr(2'b00, 16'h0002);
        cnt = 16'd500; pin_in = 1'b0; tick(4);
        check("R5 fall value", ch_value, 500);
        clear_flag();
        cnt = 16'd600; pin_in = 1'b1; tick(5);
        check("R5 rise ignored flag", ch_flag, 0);
        check("R5 rise ignored value", ch_value, 500);
        wr(2'b00, 16'h0003);
        cnt = 16'd900; pin_in = 1'b0; tick(4);
        check("R5 both fall", ch_value, 900);
        clear_flag();
        cnt = 16'd901; pin_in = 1'b1; tick(4);
        check("R5 both rise", ch_value, 901);
        check("R5 both flag", ch_flag, 1);
    endtask

    task automatic t_release_again();
        wr(2'b00, 16'h0000);
        gpio_out = 1'b1; gpio_oe = 1'b1; #1;
        check("R3 released again", {pin_oe, pin_out}, 3);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_lock();
        t_release();
        t_compare();
        t_overflow();
        t_flag_race();
        t_capture();
        t_release_again();
        finish_run();
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule